// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block arbitrates five interrupt sources for a small microcontroller core and tells the core where to call. Two of the sources are external pins. Each pin can be sensed on a falling edge or on a low level. Two are timer overflow strobes. The fifth is a serial source that raises a request while the serial logic holds either its transmit-done flag or its receive-done flag. Each source has an enable bit and a priority bit, and a global enable gates all of them.

The core asserts a strobe at each instruction boundary, and the controller decides only on that strobe. When it accepts a request, it drives the fixed vector address of the winning source with a one-cycle take pulse and an idle-exit pulse. It then waits for the core to acknowledge. A two-entry level stack tracks nesting, so a high-priority request can preempt a low-priority handler. The core pops the stack with a return pulse. The controller clears the request flags of external and timer sources when it accepts them. It never touches the serial flags, which the serial logic and software own.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `takeVld` and `idleClear` are 0, `nestDepth` is 0 and `pendFlags` is 0, provided both pins are high and no other input is active.
- R2: In edge mode (`extEdge[k]`=1), pin k going from 1 to 0 between two consecutive clock samples sets that pin's pending flag. The flag is visible one cycle after the low sample. A rising edge or a steady level leaves the flag unchanged.
- R3: In level mode (`extEdge[k]`=0), pin k's pending flag is the inverse of the pin, registered with one cycle of latency.
- R4: A one-cycle high on `tmrOvf[k]` sets timer k's pending flag, which stays set until that source is accepted.
- R5: No take occurs while `globalEn` is 0. A source whose `srcEnable` bit is 0 is never taken.
- R6: Source indices are ext0=0, timer0=1, ext1=2, timer1=3 and serial=4. Vector addresses are 0x0003 + 8*index: 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. `pendFlags[3:0]` shows the flags of indices 0..3.
- R7: Among eligible sources at the same priority, the lowest index wins.
- R8: A `srcHigh` bit of 1 marks the source as high priority. An eligible high source wins over any low source, whatever their order.
- R9: A request is taken only when no handler is active, or when it is high and the only active handler is low. `nestDepth` counts active handlers and never exceeds 2. After a pop, the remaining level governs preemption.
- R10: Accepting an external or timer source clears its pending flag. Accepting the serial source does not clear either serial flag, so the serial source is taken again at a later boundary while its flag stays high.
- R11: Requests are evaluated only in a cycle with `instBoundary` high. `takeVld` lasts one cycle. After a take, no further take occurs until `takeAck` has been seen.
- R12: A `retiPulse` pops one level (and has no effect at depth 0). A boundary in the same cycle as `retiPulse` accepts nothing.
- R13: `idleClear` pulses in the same cycle as every `takeVld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPin | input | 2 | External interrupt pins, active low (bit k = pin k) |
| extEdge | input | 2 | Sense mode per pin: 1 falling edge, 0 low level |
| tmrOvf | input | 2 | Timer overflow strobes |
| serTxDone | input | 1 | Serial transmit-done flag |
| serRxDone | input | 1 | Serial receive-done flag |
| srcEnable | input | 5 | Per-source enable, indexed as in R6 |
| srcHigh | input | 5 | Per-source priority, 1 = high |
| globalEn | input | 1 | Global interrupt enable |
| instBoundary | input | 1 | Instruction-boundary strobe from the core |
| retiPulse | input | 1 | Return-from-interrupt pulse |
| takeAck | input | 1 | Core acknowledge of a take |
| takeVld | output | 1 | One-cycle vector-call request |
| vecAddr | output | 16 | Vector address of the accepted source |
| idleClear | output | 1 | Pulse that ends idle mode |
| nestDepth | output | 2 | Number of active handlers |
| pendFlags | output | 4 | Pending flags of ext0, timer0, ext1, timer1 |

## Verification
The hardest state to reach is a full stack whose bottom entry is low, with a high request held pending that must stay blocked until exactly one return. The bench first takes an edge-sensed pin request at low priority. It then raises a high timer request and lets it preempt. While at depth 2, it promotes a further pending timer source to high. A boundary at that point must take nothing. After one return pulse the same boundary must take the promoted source. A second hard case is a boundary that arrives while the previous take is still unacknowledged, together with a boundary that coincides with a return pulse.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_EXT  = 2;
  localparam int NUM_TMR  = NUM_EXT;
  localparam int NUM_FLAG = NUM_EXT + NUM_TMR;
  localparam int NUM_SRC  = NUM_FLAG + 1;
  localparam int SER_IDX  = NUM_FLAG;
  localparam int IDX_W    = $clog2(NUM_SRC);

  typedef struct packed {
    logic             accept;
    logic [IDX_W-1:0] winIdx;
    logic             winHigh;
    logic             pop;
  } irqc_strobe_t;
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EXT-1:0]  extPin,
  input  logic [NUM_EXT-1:0]  extEdge,
  input  logic [NUM_TMR-1:0]  tmrOvf,
  input  logic                serTxDone,
  input  logic                serRxDone,
  input  irqc_strobe_t        strb,
  output logic [NUM_SRC-1:0]  reqVec,
  output logic [1:0]          depth,
  output logic                topHigh,
  output logic                takeVld,
  output logic [ADDR_W-1:0]   vecAddr,
  output logic                idleClear,
  output logic [NUM_FLAG-1:0] pendFlags
);
  logic [NUM_FLAG-1:0] flagQ, flagNext, clrVec;
  logic [NUM_EXT-1:0]  pinPrev;
  logic [1:0]          lvlQ;
  logic [1:0]          depthQ;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FLAG; gi++) begin : g_clr
      assign clrVec[gi] = strb.accept && (strb.winIdx == IDX_W'(gi));
    end
    for (gi = 0; gi < NUM_EXT; gi++) begin : g_ext
      logic fallSeen;
      assign fallSeen = pinPrev[gi] && !extPin[gi];
      // edge mode: new edge wins over the accept clear; level mode follows pin
      assign flagNext[2*gi] = extEdge[gi]
          ? (fallSeen || (flagQ[2*gi] && !clrVec[2*gi]))
          : (!extPin[gi] && !clrVec[2*gi]);
    end
    for (gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
      assign flagNext[2*gi+1] = tmrOvf[gi] || (flagQ[2*gi+1] && !clrVec[2*gi+1]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ   <= '0;
      pinPrev <= '1;
    end else begin
      flagQ   <= flagNext;
      pinPrev <= extPin;
    end
  end

  // two-entry level stack
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ   <= '0;
      depthQ <= '0;
    end else if (strb.accept) begin
      lvlQ[depthQ[0]] <= strb.winHigh;
      depthQ          <= depthQ + 2'd1;
    end else if (strb.pop && depthQ != 2'd0) begin
      depthQ <= depthQ - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeVld   <= 1'b0;
      idleClear <= 1'b0;
      vecAddr   <= '0;
    end else begin
      takeVld   <= strb.accept;
      idleClear <= strb.accept;
      if (strb.accept)
        vecAddr <= ADDR_W'(VEC_BASE) + ADDR_W'(strb.winIdx) * ADDR_W'(VEC_STRIDE);
    end
  end

  assign reqVec    = {serTxDone || serRxDone, flagQ};
  assign depth     = depthQ;
  assign topHigh   = (depthQ == 2'd2) ? lvlQ[1] : lvlQ[0];
  assign pendFlags = flagQ;
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqVec,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcHigh,
  input  logic               globalEn,
  input  logic               instBoundary,
  input  logic               retiPulse,
  input  logic               takeAck,
  input  logic [1:0]         depth,
  input  logic               topHigh,
  output irqc_strobe_t       strb
);
  logic               waitQ;
  logic [NUM_SRC-1:0] eligible, hiSet, loSet;
  logic               allowHi, allowLo, takeHi, takeLo;

  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign eligible = reqVec & srcEnable & {NUM_SRC{globalEn}};
  assign hiSet    = eligible & srcHigh;
  assign loSet    = eligible & ~srcHigh;
  assign allowHi  = (depth == 2'd0) || (depth == 2'd1 && !topHigh);
  assign allowLo  = (depth == 2'd0);
  assign takeHi   = |hiSet && allowHi;
  assign takeLo   = |loSet && allowLo;

  always_comb begin
    strb         = '0;
    strb.pop     = retiPulse;
    strb.accept  = instBoundary && !waitQ && !retiPulse && (takeHi || takeLo);
    strb.winHigh = takeHi;
    strb.winIdx  = takeHi ? firstSet(hiSet) : firstSet(loSet);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            waitQ <= 1'b0;
    else if (strb.accept) waitQ <= 1'b1;
    else if (takeAck)     waitQ <= 1'b0;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EXT-1:0]  extPin,
  input  logic [NUM_EXT-1:0]  extEdge,
  input  logic [NUM_TMR-1:0]  tmrOvf,
  input  logic                serTxDone,
  input  logic                serRxDone,
  input  logic [NUM_SRC-1:0]  srcEnable,
  input  logic [NUM_SRC-1:0]  srcHigh,
  input  logic                globalEn,
  input  logic                instBoundary,
  input  logic                retiPulse,
  input  logic                takeAck,
  output logic                takeVld,
  output logic [ADDR_W-1:0]   vecAddr,
  output logic                idleClear,
  output logic [1:0]          nestDepth,
  output logic [NUM_FLAG-1:0] pendFlags
);
  irqc_strobe_t       strb;
  logic [NUM_SRC-1:0] reqVec;
  logic               topHigh;

  irqc_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .srcEnable(srcEnable),
    .srcHigh(srcHigh), .globalEn(globalEn), .instBoundary(instBoundary),
    .retiPulse(retiPulse), .takeAck(takeAck), .depth(nestDepth),
    .topHigh(topHigh), .strb(strb)
  );

  irqc_datapath #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_dp (
    .clk(clk), .rstN(rstN), .extPin(extPin), .extEdge(extEdge), .tmrOvf(tmrOvf),
    .serTxDone(serTxDone), .serRxDone(serRxDone), .strb(strb), .reqVec(reqVec),
    .depth(nestDepth), .topHigh(topHigh), .takeVld(takeVld), .vecAddr(vecAddr),
    .idleClear(idleClear), .pendFlags(pendFlags)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        instBoundary,
  input logic        globalEn,
  input logic        retiPulse,
  input logic        takeVld,
  input logic [15:0] vecAddr,
  input logic        idleClear,
  input logic [1:0]  nestDepth
);
  a_r5_no_take_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    (instBoundary && !globalEn) |=> !takeVld);

  a_r11_needs_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !instBoundary |=> !takeVld);

  a_r11_single_cycle_take: assert property (@(posedge clk) disable iff (!rstN)
    takeVld |=> !takeVld);

  a_r9_depth_bounded: assert property (@(posedge clk) disable iff (!rstN)
    nestDepth != 2'd3);

  a_r9_take_pushes: assert property (@(posedge clk) disable iff (!rstN)
    takeVld |-> nestDepth == 2'($past(nestDepth) + 2'd1));

  a_r12_return_pops: assert property (@(posedge clk) disable iff (!rstN)
    (retiPulse && nestDepth != 2'd0) |=> nestDepth == 2'($past(nestDepth) - 2'd1));

  a_r6_vector_legal: assert property (@(posedge clk) disable iff (!rstN)
    takeVld |-> (vecAddr == 16'h0003 || vecAddr == 16'h000B || vecAddr == 16'h0013 ||
                 vecAddr == 16'h001B || vecAddr == 16'h0023));

  a_r13_idle_exit_with_take: assert property (@(posedge clk) disable iff (!rstN)
    takeVld |-> idleClear);
endmodule

bind irq_vector_ctrl irqc_checker u_chk (
  .clk(clk), .rstN(rstN), .instBoundary(instBoundary), .globalEn(globalEn),
  .retiPulse(retiPulse), .takeVld(takeVld), .vecAddr(vecAddr),
  .idleClear(idleClear), .nestDepth(nestDepth)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  extPin = 2'b11;
  logic [1:0]  extEdge = 2'b01;
  logic [1:0]  tmrOvf = 2'b00;
  logic        serTxDone = 1'b0, serRxDone = 1'b0;
  logic [4:0]  srcEnable = 5'b11111;
  logic [4:0]  srcHigh = 5'b00000;
  logic        globalEn = 1'b0;
  logic        instBoundary = 1'b0, retiPulse = 1'b0, takeAck = 1'b0;
  logic        takeVld, idleClear;
  logic [15:0] vecAddr;
  logic [1:0]  nestDepth;
  logic [3:0]  pendFlags;

  int    nChecks = 0;
  int    nFails = 0;
  string curTag = "R1";
  logic [15:0] expQ[$];

  always #4 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .extEdge(extEdge), .tmrOvf(tmrOvf),
    .serTxDone(serTxDone), .serRxDone(serRxDone), .srcEnable(srcEnable),
    .srcHigh(srcHigh), .globalEn(globalEn), .instBoundary(instBoundary),
    .retiPulse(retiPulse), .takeAck(takeAck), .takeVld(takeVld), .vecAddr(vecAddr),
    .idleClear(idleClear), .nestDepth(nestDepth), .pendFlags(pendFlags)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: every take is compared against the head of the expected queue
  always @(negedge clk) begin
    if (rstN && takeVld) begin
      if (expQ.size() == 0) check({curTag, " unexpected take"}, int'(vecAddr), 0);
      else check({curTag, " vector"}, int'(vecAddr), int'(expQ.pop_front()));
    end
  end

  task automatic boundary(string tag, bit expTake, logic [15:0] vec, bit ack = 1'b1);
    curTag = tag;
    if (expTake) expQ.push_back(vec);
    instBoundary = 1'b1;
    @(negedge clk);
    instBoundary = 1'b0;
    check({tag, " take"}, int'(takeVld), int'(expTake));
    if (expTake) check("R13 idle exit", int'(idleClear), 1);
    if (expTake && ack) begin
      takeAck = 1'b1;
      @(negedge clk);
      takeAck = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic reti();
    retiPulse = 1'b1;
    @(negedge clk);
    retiPulse = 1'b0;
  endtask

  task automatic tmrPulse(logic [1:0] which);
    tmrOvf = which;
    @(negedge clk);
    tmrOvf = 2'b00;
  endtask

  task automatic ext0Edge();
    extPin[0] = 1'b0;
    @(negedge clk);
    extPin[0] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 takeVld", int'(takeVld), 0);
    check("R1 idleClear", int'(idleClear), 0);
    check("R1 nestDepth", int'(nestDepth), 0);
    check("R1 pendFlags", int'(pendFlags), 0);

    // R2 edge sensing on ext0
    extPin[0] = 1'b0;
    @(negedge clk);
    check("R2 fall sets flag", int'(pendFlags[0]), 1);
    extPin[0] = 1'b1;
    @(negedge clk);
    check("R2 rise keeps flag", int'(pendFlags[0]), 1);

    // R5 masking
    boundary("R5 global off", 1'b0, 16'h0);
    globalEn = 1'b1;
    srcEnable[0] = 1'b0;
    boundary("R5 source off", 1'b0, 16'h0);
    srcEnable[0] = 1'b1;
    boundary("R6 ext0", 1'b1, 16'h0003);
    check("R10 ext0 flag cleared", int'(pendFlags[0]), 0);
    check("R9 depth after take", int'(nestDepth), 1);
    reti();
    check("R12 depth after return", int'(nestDepth), 0);

    // R3 level sensing on ext1
    extPin[1] = 1'b0;
    @(negedge clk);
    check("R3 low pin", int'(pendFlags[2]), 1);
    extPin[1] = 1'b1;
    @(negedge clk);
    check("R3 high pin", int'(pendFlags[2]), 0);

    // R4 timer flag latch, R11 no take without boundary
    tmrPulse(2'b10);
    repeat (3) @(negedge clk);
    check("R4 timer1 held", int'(pendFlags[3]), 1);
    check("R11 idle without boundary", int'(takeVld), 0);

    // R7 order at equal priority
    tmrPulse(2'b01);
    boundary("R7 timer0 first", 1'b1, 16'h000B);
    reti();
    boundary("R7 timer1 next", 1'b1, 16'h001B);
    reti();
    check("R10 timer flags cleared", int'(pendFlags), 0);

    // R8 priority beats order
    tmrPulse(2'b11);
    srcHigh = 5'b01000;
    boundary("R8 high timer1", 1'b1, 16'h001B);
    boundary("R9 low blocked by high", 1'b0, 16'h0);
    reti();
    boundary("R8 low after return", 1'b1, 16'h000B);
    reti();
    srcHigh = 5'b00000;

    // R9 nesting
    ext0Edge();
    tmrPulse(2'b01);
    boundary("R9 ext0 low", 1'b1, 16'h0003);
    boundary("R9 low over low", 1'b0, 16'h0);
    srcHigh = 5'b01000;
    tmrPulse(2'b10);
    boundary("R9 high preempts low", 1'b1, 16'h001B);
    check("R9 depth two", int'(nestDepth), 2);
    srcHigh = 5'b01010;
    boundary("R9 full stack", 1'b0, 16'h0);
    reti();
    check("R12 pop to one", int'(nestDepth), 1);
    boundary("R9 preempt after pop", 1'b1, 16'h000B);
    reti();
    reti();
    check("R9 depth back to zero", int'(nestDepth), 0);
    srcHigh = 5'b00000;

    // R10 serial shared vector, flags untouched
    serTxDone = 1'b1;
    boundary("R6 serial tx", 1'b1, 16'h0023);
    reti();
    boundary("R10 serial retaken", 1'b1, 16'h0023);
    reti();
    serTxDone = 1'b0;
    serRxDone = 1'b1;
    boundary("R10 serial rx", 1'b1, 16'h0023);
    reti();
    serRxDone = 1'b0;

    // R11 hold until acknowledge
    tmrPulse(2'b01);
    boundary("R11 take no ack", 1'b1, 16'h000B, 1'b0);
    srcHigh = 5'b01000;
    tmrPulse(2'b10);
    boundary("R11 waiting for ack", 1'b0, 16'h0);
    takeAck = 1'b1;
    @(negedge clk);
    takeAck = 1'b0;
    boundary("R11 after ack", 1'b1, 16'h001B);
    reti();
    reti();
    srcHigh = 5'b00000;

    // R12 return at depth zero and return with boundary
    reti();
    check("R12 empty pop", int'(nestDepth), 0);
    tmrPulse(2'b01);
    curTag = "R12 boundary with return";
    instBoundary = 1'b1;
    retiPulse = 1'b1;
    @(negedge clk);
    instBoundary = 1'b0;
    retiPulse = 1'b0;
    check("R12 boundary with return", int'(takeVld), 0);
    @(negedge clk);
    boundary("R12 later boundary", 1'b1, 16'h000B);
    reti();

    check("R6 all expected takes seen", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule